// File: doc/BRIEF.md
# Channel Conversion Sequencer with Settling

The block sequences conversions of an external analog-to-digital converter over a set of enabled channels. A trigger starts a pass that visits every enabled channel once, lowest index first, and skips the disabled ones. Before each conversion there is a tracking phase of programmable length. When the analog setup of the channel about to be converted differs from the setup of the channel converted just before it, the block can first insert a settling wait of programmable length. The setup covers the gain code, the offset bit and the single-ended/differential bit.

The converter sits outside the block behind a small handshake. The block pulses a start strobe and presents the channel index. The converter later returns a result together with a valid strobe. Each result is packed into a 16-bit word, with the data right-aligned and the channel number optionally placed in the top nibble. The word is held in a last-result register, and a single-cycle DMA request follows each update. Every trigger repeats the same channel order, so a DMA buffer receives the same layout on every pass.

Top module: `chan_conv_seq`

## Requirements
- R1: On a trigger in idle with a non-zero enable mask, each enabled channel is converted exactly once, in ascending index order. `conv_ch` holds the channel being converted while `conv_start` is high.
- R2: A settling wait of `settle_cnt` cycles comes before tracking when `settle_en` is 1, `settle_cnt` is non-zero, and the channel's {gain, offset, differential} setup differs from that of the last converted channel. The last converted channel may belong to an earlier pass. The first conversion after reset never settles.
- R3: With `settle_en` at 0, no settling wait is inserted, even when setups differ.
- R4: Tracking lasts `track_cnt`+1 cycles. `conv_start` is a one-cycle pulse that rises `settle`+`track_cnt`+1 cycles after the edge that started the channel. That edge is either the trigger edge or the result edge of the previous channel.
- R5: On the edge where `conv_valid` is sampled during a conversion, `lcd_word[11:0]` takes `conv_data`.
- R6: With `tag_en` at 1 at that edge, `lcd_word[15:12]` holds the channel index. With `tag_en` at 0, these bits are zero.
- R7: Each update of `lcd_word` is followed by a `dma_req` pulse exactly one cycle long, high in the second cycle after the update edge.
- R8: A trigger is ignored while a pass is running. A trigger with an all-zero mask starts nothing.
- R9: A pass produces exactly as many DMA requests as the mask has set bits. The next pass repeats the same channel order.
- R10: After reset, `conv_start`, `dma_req` and `lcd_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Starts a pass when idle |
| ch_en | input | 16 | Channel enable mask |
| ch_gain | input | 32 | 2-bit gain code per channel, channel n at bits 2n+1:2n |
| ch_offs | input | 16 | Offset bit per channel |
| ch_diff | input | 16 | Differential bit per channel |
| settle_cnt | input | 8 | Settling wait length in cycles |
| track_cnt | input | 8 | Tracking length minus one |
| settle_en | input | 1 | Allows settling waits |
| tag_en | input | 1 | Puts channel index in bits 15:12 |
| conv_start | output | 1 | One-cycle start to converter |
| conv_ch | output | 4 | Channel being converted |
| conv_valid | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result |
| lcd_word | output | 16 | Last converted word |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
Call the edge that starts a channel E. That edge is either the trigger edge or the previous channel's result edge. The start pulse follows E by the settle time plus `track_cnt`+1 cycles. The result edge comes a fixed converter latency later, and the DMA request is visible one edge after the result edge. The bench adds these delays up per channel to get the exact cycle of every request. It samples at falling edges and compares both the cycle number and the packed word at that cycle. After each pass, a quiet window confirms that no extra requests appear.

// File: rtl/chan_conv_seq_pkg.sv
package chan_conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_TRACK  = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/ccs_chan_pick.sv
// Finds the lowest enabled channel, either anywhere (from_start) or above cur_ch.
module ccs_chan_pick #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] en_mask,
    input  logic [CH_W-1:0]   cur_ch,
    input  logic              from_start,
    output logic              found,
    output logic [CH_W-1:0]   next_ch
);
    always_comb begin
        found   = 1'b0;
        next_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en_mask[i] && (from_start || (i > int'(cur_ch)))) begin
                found   = 1'b1;
                next_ch = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/ccs_cfg_cmp.sv
// Compares the analog setup (gain, offset, differential) of two channels.
module ccs_cfg_cmp #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int GAIN_W = 2
) (
    input  logic [NUM_CH*GAIN_W-1:0] gain_vec,
    input  logic [NUM_CH-1:0]        offs_vec,
    input  logic [NUM_CH-1:0]        diff_vec,
    input  logic [CH_W-1:0]          ch_a,
    input  logic [CH_W-1:0]          ch_b,
    output logic                     differs
);
    localparam int CFG_W = GAIN_W + 2;

    logic [CFG_W-1:0] cfg [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
        assign cfg[g] = {gain_vec[g*GAIN_W +: GAIN_W], offs_vec[g], diff_vec[g]};
    end

    assign differs = (cfg[ch_a] != cfg[ch_b]);
endmodule

// File: rtl/ccs_word_pack.sv
// Right-aligns the result and optionally puts the channel index in the top field.
module ccs_word_pack #(
    parameter int DATA_W = 12,
    parameter int WORD_W = 16,
    parameter int CH_W   = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CH_W-1:0]   ch,
    input  logic              tag_en,
    output logic [WORD_W-1:0] word
);
    localparam int TAG_W = WORD_W - DATA_W;

    logic [TAG_W-1:0] tag_field;

    if (TAG_W >= CH_W) begin : g_fit
        assign tag_field = tag_en ? TAG_W'(ch) : '0;
    end else begin : g_trunc
        assign tag_field = tag_en ? ch[TAG_W-1:0] : '0;
    end

    assign word = {tag_field, data};
endmodule

// File: rtl/chan_conv_seq.sv
module chan_conv_seq
    import chan_conv_seq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 12,
    parameter int WORD_W = 16,
    parameter int GAIN_W = 2,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*GAIN_W-1:0] ch_gain,
    input  logic [NUM_CH-1:0]        ch_offs,
    input  logic [NUM_CH-1:0]        ch_diff,
    input  logic [CNT_W-1:0]         settle_cnt,
    input  logic [CNT_W-1:0]         track_cnt,
    input  logic                     settle_en,
    input  logic                     tag_en,
    output logic                     conv_start,
    output logic [$clog2(NUM_CH)-1:0] conv_ch,
    input  logic                     conv_valid,
    input  logic [DATA_W-1:0]        conv_data,
    output logic [WORD_W-1:0]        lcd_word,
    output logic                     dma_req
);
    localparam int CH_W = $clog2(NUM_CH);

    typedef struct packed {
        seq_state_e        st;
        logic [CH_W-1:0]   ch;
        logic [CNT_W-1:0]  cnt;
        logic [CH_W-1:0]   prev_ch;
        logic              prev_vld;
        logic              start;
        logic              wr;
        logic              dma;
        logic [WORD_W-1:0] word;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st:       ST_IDLE,
        ch:       '0,
        cnt:      '0,
        prev_ch:  '0,
        prev_vld: 1'b0,
        start:    1'b0,
        wr:       1'b0,
        dma:      1'b0,
        word:     '0
    };

    seq_regs_t r_q, r_d;

    // next enabled channel
    logic            pick_found;
    logic [CH_W-1:0] pick_ch;

    ccs_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .en_mask   (ch_en),
        .cur_ch    (r_q.ch),
        .from_start(r_q.st == ST_IDLE),
        .found     (pick_found),
        .next_ch   (pick_ch)
    );

    // setup comparison against the channel converted last
    logic            ref_vld;
    logic [CH_W-1:0] ref_ch;
    logic            cfg_differs;
    logic            need_settle;

    assign ref_vld = (r_q.st == ST_CONV) || r_q.prev_vld;
    assign ref_ch  = (r_q.st == ST_CONV) ? r_q.ch : r_q.prev_ch;

    ccs_cfg_cmp #(.NUM_CH(NUM_CH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_cmp (
        .gain_vec(ch_gain),
        .offs_vec(ch_offs),
        .diff_vec(ch_diff),
        .ch_a    (pick_ch),
        .ch_b    (ref_ch),
        .differs (cfg_differs)
    );

    assign need_settle = settle_en && (settle_cnt != '0) && ref_vld && cfg_differs;

    // result packing
    logic [WORD_W-1:0] packed_word;

    ccs_word_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_pack (
        .data  (conv_data),
        .ch    (r_q.ch),
        .tag_en(tag_en),
        .word  (packed_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        r_d.wr    = 1'b0;
        r_d.dma   = r_q.wr;
        case (r_q.st)
            ST_IDLE: begin
                if (trig && pick_found) begin
                    r_d.ch = pick_ch;
                    if (need_settle) begin
                        r_d.st  = ST_SETTLE;
                        r_d.cnt = settle_cnt - 1'b1;
                    end else begin
                        r_d.st  = ST_TRACK;
                        r_d.cnt = track_cnt;
                    end
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_TRACK;
                    r_d.cnt = track_cnt;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TRACK: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_CONV;
                    r_d.start = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_valid) begin
                    r_d.word     = packed_word;
                    r_d.wr       = 1'b1;
                    r_d.prev_ch  = r_q.ch;
                    r_d.prev_vld = 1'b1;
                    if (pick_found) begin
                        r_d.ch = pick_ch;
                        if (need_settle) begin
                            r_d.st  = ST_SETTLE;
                            r_d.cnt = settle_cnt - 1'b1;
                        end else begin
                            r_d.st  = ST_TRACK;
                            r_d.cnt = track_cnt;
                        end
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign conv_start = r_q.start;
    assign conv_ch    = r_q.ch;
    assign lcd_word   = r_q.word;
    assign dma_req    = r_q.dma;

    AST_START_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4
    AST_DMA_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R7
    AST_DMA_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(conv_valid, 2)); // R7
    AST_WORD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV && conv_valid) |=> (lcd_word[DATA_W-1:0] == $past(conv_data))); // R5
    AST_SETTLE_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SETTLE) |-> settle_en); // R3
    AST_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ch_en[conv_ch]); // R1
endmodule

// File: tb/chan_conv_seq_tb_top.sv
module chan_conv_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] ch_en = '0;
    logic [31:0] ch_gain = '0;
    logic [15:0] ch_offs = '0;
    logic [15:0] ch_diff = '0;
    logic [7:0]  settle_cnt = '0;
    logic [7:0]  track_cnt = '0;
    logic        settle_en = 1'b0;
    logic        tag_en = 1'b0;
    logic        conv_start;
    logic [3:0]  conv_ch;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;
    logic [15:0] lcd_word;
    logic        dma_req;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit have_prev = 0;
    int prev_ch = 0;
    logic [11:0] salt = '0;

    chan_conv_seq dut_i (
        .clk(clk), .rst_n(rst_n), .trig(trig), .ch_en(ch_en), .ch_gain(ch_gain),
        .ch_offs(ch_offs), .ch_diff(ch_diff), .settle_cnt(settle_cnt),
        .track_cnt(track_cnt), .settle_en(settle_en), .tag_en(tag_en),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_valid(conv_valid),
        .conv_data(conv_data), .lcd_word(lcd_word), .dma_req(dma_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] data_of(int ch);
        return 12'((ch * 251) ^ salt);
    endfunction

    function automatic logic [3:0] cfg_of(int ch);
        return {ch_gain[2*ch +: 2], ch_offs[ch], ch_diff[ch]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // converter model: fixed latency from start to valid
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                automatic int c = int'(conv_ch);
                repeat (LAT - 1) @(negedge clk);
                conv_valid = 1'b1;
                conv_data  = data_of(c);
                @(negedge clk);
                conv_valid = 1'b0;
            end
        end
    end

    task automatic run_pass(bit extra_trig);
        int exp_cyc [NCH];
        logic [15:0] exp_word [NCH];
        int n = 0;
        int t;
        int got = 0;
        int quiet = 0;
        @(negedge clk);
        t = cyc + 1;
        for (int ch = 0; ch < NCH; ch++) begin
            if (ch_en[ch]) begin
                int s;
                s = (settle_en && settle_cnt != 0 && have_prev && cfg_of(ch) != cfg_of(prev_ch))
                    ? int'(settle_cnt) : 0;
                t = t + s + int'(track_cnt) + 1 + LAT;
                exp_cyc[n]  = t + 1;
                exp_word[n] = {tag_en ? 4'(ch) : 4'h0, data_of(ch)};
                prev_ch = ch;
                have_prev = 1;
                n++;
            end
        end
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        if (extra_trig) begin
            @(negedge clk);
            trig = 1'b1;   // R8: pass already running
            @(negedge clk);
            trig = 1'b0;
        end
        for (int k = 0; k < n; k++) begin
            int limit;
            limit = exp_cyc[k] + 20;
            while (!dma_req && cyc < limit) @(negedge clk);
            check(cyc == exp_cyc[k], "R2/R3/R4", "dma cycle", cyc, exp_cyc[k]);
            check(lcd_word[11:0] == exp_word[k][11:0], "R5", "data field",
                  int'(lcd_word[11:0]), int'(exp_word[k][11:0]));
            check(lcd_word[15:12] == exp_word[k][15:12], "R1 R6", "tag field",
                  int'(lcd_word[15:12]), int'(exp_word[k][15:12]));
            if (dma_req) got++;
            @(negedge clk);
            check(!dma_req, "R7", "dma pulse width", int'(dma_req), 0);
        end
        repeat (40) begin
            @(negedge clk);
            if (dma_req) quiet++;
        end
        check(got == n && quiet == 0, "R8 R9", "requests per pass", got + quiet, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'h1dc0_ffee));
        repeat (3) @(negedge clk);
        check(conv_start == 0, "R10", "conv_start at reset", int'(conv_start), 0);
        check(dma_req == 0, "R10", "dma_req at reset", int'(dma_req), 0);
        check(lcd_word == 0, "R10", "lcd_word at reset", int'(lcd_word), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: first pass, identical setups, no settling
        ch_en = 16'hFFFF; settle_en = 1; settle_cnt = 5; track_cnt = 2; tag_en = 1;
        salt = 12'h3A5;
        run_pass(0);
        // R9: repeat the same pass
        run_pass(0);

        // R3: differing setups, settling disabled
        ch_gain = 32'h1B1B_E4E4; ch_offs = 16'hA5A5; ch_diff = 16'h0F0F;
        ch_en = 16'h5AF3; settle_en = 0; settle_cnt = 6; track_cnt = 1;
        run_pass(0);

        // R2: differing setups, settling enabled
        settle_en = 1; settle_cnt = 4; track_cnt = 0; tag_en = 0;
        run_pass(0);

        // R2: zero settling count
        settle_cnt = 0; track_cnt = 3; tag_en = 1;
        run_pass(0);

        // R8: empty mask starts nothing
        ch_en = 16'h0000;
        run_pass(0);

        // R6, R8: single top channel, tag off, retrigger during pass
        ch_en = 16'h8000; tag_en = 0; settle_cnt = 3;
        run_pass(1);
        tag_en = 1;
        run_pass(1);

        for (int it = 0; it < 25; it++) begin
            ch_en      = 16'($urandom);
            ch_gain    = $urandom;
            ch_offs    = 16'($urandom);
            ch_diff    = 16'($urandom);
            settle_cnt = 8'($urandom_range(0, 7));
            track_cnt  = 8'($urandom_range(0, 5));
            settle_en  = 1'($urandom);
            tag_en     = 1'($urandom);
            salt       = 12'($urandom);
            run_pass(1'($urandom));
        end
        report();
    end
endmodule